// File: doc/BRIEF.md
# PHY Timing-Error Overflow Counter

This block counts receiver timing errors of two kinds, one channel for OFDM and one for CCK. Each hardware counter starts from a preload equal to its all-ones value minus a per-channel threshold, so the counter carries out of its top bit on exactly the error that pushes the count past the threshold. That carry raises an interrupt. A snapshot strobe reads both counters, turns each raw value back into an error count, reloads the counters to their preload in the same cycle, and adds every positive count into a per-period total and a lifetime total.

A snapshot in which neither channel has a positive count is treated as empty, for example a second interrupt that arrives after the counters were already reloaded. Such a snapshot changes nothing. After a productive snapshot, a one-cycle evaluate request goes out if either period total now exceeds its threshold. Older receivers without counters flag each errored frame instead. In that per-frame mode each error pulse adds one to the matching totals directly, and the evaluate request fires as soon as a total passes its threshold. A period-clear strobe empties the period totals and leaves the lifetime totals alone.

Top module: `perr_overflow_unit`

## Requirements
- R1: After reset every total is zero, and both `irq` and `eval_req` are low.
- R2: On the first clock edge with `enable` high and `frame_mode` low, each counter loads all-ones minus its own threshold. A snapshot taken with no errors since that load is empty, and n errors then give a count of n.
- R3: `irq` rises on the error that carries a counter out of its all-ones value, which is error threshold+1 after a load. It does not rise on error threshold. Once high it stays high until a snapshot is taken, and the snapshot clears it.
- R4: A snapshot converts each raw value, with the carry weighted as 2^CNT_W, into threshold − (all-ones − raw).
- R5: A snapshot reloads both counters to their preload in the same cycle. An error arriving in that cycle is counted in the new window.
- R6: If neither converted count is above zero, the snapshot leaves every total unchanged and raises no evaluate request.
- R7: A positive converted count is added to both the period total and the lifetime total of its channel. A count of zero or less adds nothing.
- R8: `eval_req` is high for the one cycle after a productive snapshot when either updated period total is greater than its threshold. The snapshot's edge is cycle 0.
- R9: While `enable` is low, both counters are held at zero, errors are ignored, `irq` is low, and a snapshot is empty.
- R10: `period_clr` zeroes both period totals and leaves the lifetime totals as they are. If a snapshot arrives in the same cycle, its counts are added onto zero.
- R11: With `enable` and `frame_mode` both high, each error pulse adds one to its channel's period and lifetime totals. `eval_req` pulses in the next cycle when that period total goes above its threshold. The hardware counters stay at zero and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Automatic error tracking on |
| frame_mode | input | 1 | Per-frame error counting instead of hardware counters |
| err_ofdm | input | 1 | One OFDM timing error per cycle high |
| err_cck | input | 1 | One CCK timing error per cycle high |
| snap | input | 1 | Read, convert and reload both counters |
| period_clr | input | 1 | Start a new period (zero period totals) |
| ofdm_total | output | TOT_W | OFDM errors this period |
| cck_total | output | TOT_W | CCK errors this period |
| ofdm_life | output | LIFE_W | OFDM errors since reset |
| cck_life | output | LIFE_W | CCK errors since reset |
| irq | output | 1 | A counter has carried past all-ones |
| eval_req | output | 1 | One-cycle request to re-evaluate immunity |

## Verification
A wrong preload does not show up until the next snapshot. An off-by-one preload appears as a total that is one too high or too low, or as an empty snapshot that adds a stray count. A wrong carry position moves the `irq` edge by one error, which is visible on the same edge as that error. A reload that misses its cycle, or a clear with the wrong priority, appears only in the totals after the following snapshot. The bench therefore compares all six outputs after every stimulus step.

// File: rtl/perr_pkg.sv
package perr_pkg;
  localparam int NCH     = 2;
  localparam int CH_OFDM = 0;
  localparam int CH_CCK  = 1;

  // Error count held in a preloaded counter; raw includes the carry bit.
  function automatic int raw_to_count(input int trig, input int cnt_max, input int raw);
    return trig - (cnt_max - raw);
  endfunction

  function automatic logic is_positive(input int v);
    return v > 0;
  endfunction
endpackage

// File: rtl/perr_counter.sv
module perr_counter #(
  parameter int CNT_W = 8,
  parameter int TRIG  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic err,
  input  logic snap,
  output logic carry,
  output int   count
);
  import perr_pkg::*;

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PRESET   = ALL_ONES - CNT_W'(TRIG);
  localparam int               CNT_MAX  = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic [CNT_W:0]   inc_w;
  logic             at_ceiling;

  assign inc_w      = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign at_ceiling = carry & (cnt == ALL_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      carry <= 1'b0;
      armed <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      carry <= 1'b0;
      armed <= 1'b0;
    end else if (snap || !armed) begin
      cnt   <= PRESET + {{(CNT_W-1){1'b0}}, err};
      carry <= 1'b0;
      armed <= 1'b1;
    end else if (err && !at_ceiling) begin
      cnt   <= inc_w[CNT_W-1:0];
      carry <= carry | inc_w[CNT_W];
    end
  end

  assign count = raw_to_count(TRIG, CNT_MAX, int'({carry, cnt}));
endmodule

// File: rtl/perr_tally.sv
module perr_tally #(
  parameter int TOT_W  = 16,
  parameter int LIFE_W = 24,
  parameter int TRIG   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [TOT_W-1:0]  add_val,
  output logic [TOT_W-1:0]  total,
  output logic [LIFE_W-1:0] life,
  output logic              over
);
  logic [TOT_W-1:0] nxt_tot;

  assign nxt_tot = (clr ? '0 : total) + (add_en ? add_val : '0);
  assign over    = nxt_tot > TOT_W'(TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      life  <= '0;
    end else begin
      total <= nxt_tot;
      if (add_en) life <= life + LIFE_W'(add_val);
    end
  end
endmodule

// File: rtl/perr_overflow_unit.sv
module perr_overflow_unit #(
  parameter int CNT_W     = 8,
  parameter int TRIG_OFDM = 20,
  parameter int TRIG_CCK  = 12,
  parameter int TOT_W     = 16,
  parameter int LIFE_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frame_mode,
  input  logic              err_ofdm,
  input  logic              err_cck,
  input  logic              snap,
  input  logic              period_clr,
  output logic [TOT_W-1:0]  ofdm_total,
  output logic [TOT_W-1:0]  cck_total,
  output logic [LIFE_W-1:0] ofdm_life,
  output logic [LIFE_W-1:0] cck_life,
  output logic              irq,
  output logic              eval_req
);
  import perr_pkg::*;

  logic [NCH-1:0]    err_v, carry_v, pos_v, inc_v, over_v, add_en_v;
  int                count_v [NCH];
  logic [TOT_W-1:0]  add_val_v [NCH];
  logic [TOT_W-1:0]  tot_v [NCH];
  logic [LIFE_W-1:0] life_v [NCH];

  // Named internal events, observed by the checker.
  logic run_w, void_w, prod_w, eval_nxt;

  assign err_v  = {err_cck, err_ofdm};
  assign run_w  = enable & ~frame_mode;
  assign void_w = snap & ~(|pos_v);
  assign prod_w = snap & ~void_w;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int TRIG_G = (g == CH_OFDM) ? TRIG_OFDM : TRIG_CCK;

    perr_counter #(.CNT_W(CNT_W), .TRIG(TRIG_G)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_w),
      .err   (err_v[g]),
      .snap  (snap),
      .carry (carry_v[g]),
      .count (count_v[g])
    );

    assign pos_v[g]     = snap & is_positive(count_v[g]);
    assign inc_v[g]     = enable & frame_mode & err_v[g];
    assign add_en_v[g]  = pos_v[g] | inc_v[g];
    assign add_val_v[g] = inc_v[g] ? TOT_W'(1) : TOT_W'(count_v[g]);

    perr_tally #(.TOT_W(TOT_W), .LIFE_W(LIFE_W), .TRIG(TRIG_G)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (period_clr),
      .add_en  (add_en_v[g]),
      .add_val (add_val_v[g]),
      .total   (tot_v[g]),
      .life    (life_v[g]),
      .over    (over_v[g])
    );
  end

  assign eval_nxt = (prod_w & (|over_v)) | (|(inc_v & over_v));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_req <= 1'b0;
    else        eval_req <= eval_nxt;
  end

  assign irq        = |carry_v;
  assign ofdm_total = tot_v[CH_OFDM];
  assign cck_total  = tot_v[CH_CCK];
  assign ofdm_life  = life_v[CH_OFDM];
  assign cck_life   = life_v[CH_CCK];
endmodule

// File: rtl/perr_overflow_chk.sv
module perr_overflow_chk #(
  parameter int TOT_W  = 16,
  parameter int LIFE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              frame_mode,
  input logic              snap,
  input logic              period_clr,
  input logic [TOT_W-1:0]  ofdm_total,
  input logic [TOT_W-1:0]  cck_total,
  input logic [LIFE_W-1:0] ofdm_life,
  input logic [LIFE_W-1:0] cck_life,
  input logic              irq,
  input logic              run_w,
  input logic              void_w
);
  p_irq_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> !irq);

  p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !snap && run_w) |=> irq);

  p_void_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (void_w && !period_clr && !frame_mode) |=>
      ($stable(ofdm_total) && $stable(cck_total) && $stable(ofdm_life) && $stable(cck_life)));

  p_life_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ofdm_life >= $past(ofdm_life) && cck_life >= $past(cck_life)));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (period_clr && !snap && !frame_mode) |=> (ofdm_total == '0 && cck_total == '0));

  p_frame_noirq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mode |=> !irq);
endmodule

bind perr_overflow_unit perr_overflow_chk #(.TOT_W(TOT_W), .LIFE_W(LIFE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .frame_mode (frame_mode),
  .snap       (snap),
  .period_clr (period_clr),
  .ofdm_total (ofdm_total),
  .cck_total  (cck_total),
  .ofdm_life  (ofdm_life),
  .cck_life   (cck_life),
  .irq        (irq),
  .run_w      (run_w),
  .void_w     (void_w)
);

// File: tb/sim_perr_overflow_unit.sv
`timescale 1ns/1ps
module sim_perr_overflow_unit;
  localparam int CW = 8, TO = 20, TC = 12, TW = 16, LW = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0, frame_mode = 1'b0;
  logic err_ofdm = 1'b0, err_cck = 1'b0, snap = 1'b0, period_clr = 1'b0;
  logic [TW-1:0] ofdm_total, cck_total;
  logic [LW-1:0] ofdm_life, cck_life;
  logic irq, eval_req;

  perr_overflow_unit #(.CNT_W(CW), .TRIG_OFDM(TO), .TRIG_CCK(TC), .TOT_W(TW), .LIFE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_mode(frame_mode),
    .err_ofdm(err_ofdm), .err_cck(err_cck), .snap(snap), .period_clr(period_clr),
    .ofdm_total(ofdm_total), .cck_total(cck_total), .ofdm_life(ofdm_life),
    .cck_life(cck_life), .irq(irq), .eval_req(eval_req)
  );

  typedef struct {
    string tag;
    int ot, ct, ol, cl, irq, ev;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic void cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endfunction

  // Monitor: pops expectations and compares at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "ofdm_total", int'(ofdm_total), e.ot);
        cmp(e.tag, "cck_total",  int'(cck_total),  e.ct);
        cmp(e.tag, "ofdm_life",  int'(ofdm_life),  e.ol);
        cmp(e.tag, "cck_life",   int'(cck_life),   e.cl);
        cmp(e.tag, "irq",        int'(irq),        e.irq);
        cmp(e.tag, "eval_req",   int'(eval_req),   e.ev);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_state(string tag, int ot, int ct, int ol, int cl, int ir, int ev);
    exp_t e;
    e.tag = tag; e.ot = ot; e.ct = ct; e.ol = ol; e.cl = cl; e.irq = ir; e.ev = ev;
    q.push_back(e);
    @(negedge clk);
    #0.5;
  endtask

  task automatic burst(logic o, logic c, int n);
    err_ofdm = o;
    err_cck  = c;
    repeat (n) step();
    err_ofdm = 1'b0;
    err_cck  = 1'b0;
  endtask

  task automatic do_snap();
    snap = 1'b1;
    step();
    snap = 1'b0;
  endtask

  task automatic do_clr();
    period_clr = 1'b1;
    step();
    period_clr = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect_state("R1 reset state", 0, 0, 0, 0, 0, 0);

    enable = 1'b1;
    step(); step();
    do_snap();
    expect_state("R2 R6 snapshot right after load", 0, 0, 0, 0, 0, 0);

    burst(1'b1, 1'b0, 5);
    burst(1'b0, 1'b1, 3);
    do_snap();
    expect_state("R4 R7 converted counts", 5, 3, 5, 3, 0, 0);

    do_snap();
    expect_state("R6 repeated snapshot is empty", 5, 3, 5, 3, 0, 0);

    burst(1'b1, 1'b0, 20);
    expect_state("R3 no irq at threshold", 5, 3, 5, 3, 0, 0);
    burst(1'b1, 1'b0, 1);
    expect_state("R3 irq on carry", 5, 3, 5, 3, 1, 0);
    step(); step();
    expect_state("R3 irq held", 5, 3, 5, 3, 1, 0);
    do_snap();
    expect_state("R4 R8 carry counted and eval", 26, 3, 26, 3, 0, 1);
    step();
    expect_state("R8 eval lasts one cycle", 26, 3, 26, 3, 0, 0);

    do_clr();
    expect_state("R10 period clear keeps lifetime", 0, 0, 26, 3, 0, 0);

    burst(1'b0, 1'b1, 13);
    expect_state("R3 cck carry irq", 0, 0, 26, 3, 1, 0);
    do_snap();
    expect_state("R8 cck eval", 0, 13, 26, 16, 0, 1);

    do_clr();
    burst(1'b1, 1'b0, 4);
    snap = 1'b1; err_ofdm = 1'b1;
    step();
    snap = 1'b0; err_ofdm = 1'b0;
    expect_state("R5 snapshot with concurrent error", 4, 0, 30, 16, 0, 0);
    do_snap();
    expect_state("R5 concurrent error in new window", 5, 0, 31, 16, 0, 0);

    burst(1'b0, 1'b1, 2);
    snap = 1'b1; period_clr = 1'b1;
    step();
    snap = 1'b0; period_clr = 1'b0;
    expect_state("R10 clear with snapshot", 0, 2, 31, 18, 0, 0);

    enable = 1'b0;
    step();
    burst(1'b1, 1'b1, 30);
    expect_state("R9 disabled ignores errors", 0, 2, 31, 18, 0, 0);
    do_snap();
    expect_state("R9 disabled snapshot empty", 0, 2, 31, 18, 0, 0);

    enable = 1'b1;
    step(); step();
    do_snap();
    expect_state("R2 reload after enable", 0, 2, 31, 18, 0, 0);
    burst(1'b1, 1'b0, 3);
    do_snap();
    expect_state("R2 count after reload", 3, 2, 34, 18, 0, 0);

    frame_mode = 1'b1;
    do_clr();
    burst(1'b0, 1'b1, 12);
    expect_state("R11 frame count at threshold", 0, 12, 34, 30, 0, 0);
    burst(1'b0, 1'b1, 1);
    expect_state("R11 frame eval above threshold", 0, 13, 34, 31, 0, 1);
    burst(1'b1, 1'b0, 1);
    expect_state("R11 ofdm frame count", 1, 13, 35, 31, 0, 0);
    do_snap();
    expect_state("R11 snapshot empty in frame mode", 1, 13, 35, 31, 0, 0);

    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule